// File: doc/BRIEF.md
# Interrupt Flag and Mask Collector

This block collects the interrupt sources of a small microcontroller and produces a single request line for the CPU core. It handles three kinds of source. The first is one external pin whose active edge (rising or falling) is selected by a control bit. The second is a group of port pins that raise a flag when any of them differs from a snapshot taken when firmware last read the port. The third is a vector of single-cycle event pulses from on-chip peripherals.

Every source owns a sticky flag and an enable bit. A flag records its event even while the source is masked. The enable bits decide whether a set flag reaches the request line. The peripheral sources sit behind an extra group enable. A global enable gates everything.

Firmware reaches all state through a write port with a per-bit mask and a zero-wait read port. Writing a 1 into a flag forces that source exactly as a hardware event would. The global enable drops when the CPU acknowledges the request and comes back on a return-from-interrupt pulse.

Top module: `intr_gather`

## Requirements
- R1: With the edge-select bit (control register, address 0, bit 4) at 1, a rising edge on `ext_pin` sets the external flag (address 1, bit 0). With the bit at 0, a falling edge sets it. The flag is set whatever the enable bits hold. It becomes readable at the third rising clock edge after the pin changes and is still clear at the second.
- R2: An edge of the non-selected polarity on `ext_pin` leaves the external flag clear.
- R3: The port-change flag (address 1, bit 1) is set in every cycle in which any synchronized port pin differs from the snapshot. A read strobe (`rd_en`) with address 1 loads the snapshot from the synchronized pins. Address 1, bits 7:4 read the synchronized pins. While a mismatch persists, a firmware clear of this flag does not stick.
- R4: A one-cycle pulse on `periph_evt[i]` sets peripheral flag i (address 2, bit i) at the next clock edge, whatever the peripheral enables (address 3, bit i) hold.
- R5: `irq_out` = global enable (addr 0 bit 0) AND ((ext flag AND ext enable, addr 0 bit 2) OR (change flag AND change enable, addr 0 bit 3) OR (group enable, addr 0 bit 1 AND any peripheral flag whose enable is set)).
- R6: A write changes only the bits of the addressed register whose `wmask` bit is 1; each such bit takes `wdata`. Writing 1 to a flag sets it, and the set flag requests an interrupt like a hardware event. Writing 0 clears it.
- R7: When a hardware event and a firmware clear of the same flag fall in one cycle, the flag ends up set.
- R8: A `cpu_ack` pulse clears the global enable, and this overrides a simultaneous write or `cpu_reti`. A `cpu_reti` pulse without `cpu_ack` sets the global enable.
- R9: After reset, every register reads 0 and `irq_out` is 0.
- R10: `rd_data` shows the addressed register in the same cycle. Bits with no field read 0: control bits 7:5, flag bits 3:2 at address 1, and peripheral bits above the peripheral count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | IOC_PINS | Port pins watched for level change, asynchronous |
| periph_evt | input | NUM_PERIPH | One-cycle peripheral event pulses |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 8 | Write data |
| wmask | input | 8 | Per-bit write mask |
| rd_en | input | 1 | Read strobe; with address 1 it refreshes the port snapshot |
| rd_data | output | 8 | Read data, combinational |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU |
| cpu_reti | input | 1 | Return-from-interrupt pulse |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps every combination of the global, group and source enables against every flag pattern, so a wrong term in the request equation shows up as a request that appears or goes missing. It checks the external flag one cycle before and one cycle at its expected arrival, for both polarities. A design with a missing synchronizer stage, or with the polarity inverted, would set the flag early or on the wrong edge. Each port pin is toggled in both directions, and the bench confirms that clearing the flag fails until the port is read, which catches a detector that only fires once. It also collides a clear with an event, and an acknowledge with a return or an enabling write, where a wrong priority would lose the flag or leave interrupts enabled.

// File: rtl/intr_gather_pkg.sv
package intr_gather_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CORE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PFLAG = 2'd2;
  localparam logic [ADDR_W-1:0] A_PEN   = 2'd3;

  localparam int CTRL_W  = 5;
  localparam int CORE_W  = 2;
  localparam int PIN_LSB = 4;

  // control register, bit 0 at the right
  typedef struct packed {
    logic rise;    // bit 4
    logic ioc_en;  // bit 3
    logic ext_en;  // bit 2
    logic pge;     // bit 1
    logic gie;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/intr_pin_detect.sv
module intr_pin_detect #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_s,
  input  logic [PINS-1:0] pins_s,
  input  logic            rise_sel,
  input  logic            snap,
  output logic            ext_evt,
  output logic            ioc_evt
);
  logic            ext_prev_q, ext_prev_d;
  logic [PINS-1:0] snap_q, snap_d;

  always_comb begin
    ext_prev_d = ext_s;
    snap_d     = snap_q;
    if (snap) snap_d = pins_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q <= 1'b0;
      snap_q     <= '0;
    end else begin
      ext_prev_q <= ext_prev_d;
      snap_q     <= snap_d;
    end
  end

  assign ext_evt = rise_sel ? (ext_s & ~ext_prev_q) : (~ext_s & ext_prev_q);
  assign ioc_evt = |(pins_s ^ snap_q);

  // R2
  ext_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |-> ((ext_s == rise_sel) && (ext_s != $past(ext_s))));

  // R3
  snap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snap) && $stable(pins_s)) |-> !ioc_evt);
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_gather_pkg::*;
#(
  parameter int NP   = 4,
  parameter int PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic              ext_evt,
  input  logic              ioc_evt,
  input  logic [NP-1:0]     periph_evt,
  input  logic              cpu_ack,
  input  logic              cpu_reti,
  input  logic [PINS-1:0]   pins_s,
  output logic              rise_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  ctrl_t           ctrl_q, ctrl_d;
  logic [CORE_W-1:0] core_q, core_d;   // {ioc, ext}
  logic [NP-1:0]   pflag_q, pflag_d;
  logic [NP-1:0]   pen_q, pen_d;
  logic            unused_bits;

  assign unused_bits = ^{wdata, wmask};

  always_comb begin
    ctrl_d  = ctrl_q;
    core_d  = core_q;
    pflag_d = pflag_q;
    pen_d   = pen_q;
    if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_d = (ctrl_q & ~wmask[CTRL_W-1:0]) | (wdata[CTRL_W-1:0] & wmask[CTRL_W-1:0]);
        A_CORE:  core_d = (core_q & ~wmask[CORE_W-1:0]) | (wdata[CORE_W-1:0] & wmask[CORE_W-1:0]);
        A_PFLAG: pflag_d = (pflag_q & ~wmask[NP-1:0]) | (wdata[NP-1:0] & wmask[NP-1:0]);
        default: pen_d = (pen_q & ~wmask[NP-1:0]) | (wdata[NP-1:0] & wmask[NP-1:0]);
      endcase
    end
    // hardware events override firmware clears
    core_d  = core_d | {ioc_evt, ext_evt};
    pflag_d = pflag_d | periph_evt;
    // acknowledge beats return and writes
    if (cpu_ack)       ctrl_d.gie = 1'b0;
    else if (cpu_reti) ctrl_d.gie = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      core_q  <= '0;
      pflag_q <= '0;
      pen_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      core_q  <= core_d;
      pflag_q <= pflag_d;
      pen_q   <= pen_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_CORE: begin
        rd_data[CORE_W-1:0]       = core_q;
        rd_data[PIN_LSB +: PINS]  = pins_s;
      end
      A_PFLAG: rd_data[NP-1:0] = pflag_q;
      default: rd_data[NP-1:0] = pen_q;
    endcase
  end

  assign rise_sel = ctrl_q.rise;
  assign irq_out  = ctrl_q.gie &
                    ((core_q[0] & ctrl_q.ext_en) |
                     (core_q[1] & ctrl_q.ioc_en) |
                     (ctrl_q.pge & |(pflag_q & pen_q)));

  // R4
  periph_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_evt) |=> ((pflag_q & $past(periph_evt)) == $past(periph_evt)));

  // R7
  ext_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> core_q[0]);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !ctrl_q.gie);

  // R8
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && !cpu_ack) |=> ctrl_q.gie);

  // R5
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && cpu_ack) |=> !irq_out);

  // R6
  pflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|periph_evt)) |=> $stable(pflag_q));
endmodule

// File: rtl/intr_gather.sv
module intr_gather
  import intr_gather_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int IOC_PINS   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_pin,
  input  logic [IOC_PINS-1:0]   port_pins,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     wmask,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  cpu_ack,
  input  logic                  cpu_reti,
  output logic                  irq_out
);
  localparam int SYNC_W = IOC_PINS + 1;

  logic              rst_meta_q, rst_sync_q;
  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              ext_s, ext_evt, ioc_evt, rise_sel, snap;
  logic [IOC_PINS-1:0] pins_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_in = {port_pins, ext_pin};

  intr_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_in  (raw_in),
    .q_out (sync_out)
  );

  assign ext_s  = sync_out[0];
  assign pins_s = sync_out[SYNC_W-1:1];
  assign snap   = rd_en && (addr == A_CORE);

  intr_pin_detect #(.PINS(IOC_PINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ext_s    (ext_s),
    .pins_s   (pins_s),
    .rise_sel (rise_sel),
    .snap     (snap),
    .ext_evt  (ext_evt),
    .ioc_evt  (ioc_evt)
  );

  intr_regs #(.NP(NUM_PERIPH), .PINS(IOC_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .wmask      (wmask),
    .ext_evt    (ext_evt),
    .ioc_evt    (ioc_evt),
    .periph_evt (periph_evt),
    .cpu_ack    (cpu_ack),
    .cpu_reti   (cpu_reti),
    .pins_s     (pins_s),
    .rise_sel   (rise_sel),
    .rd_data    (rd_data),
    .irq_out    (irq_out)
  );
endmodule

// File: tb/intr_gather_test.sv
module intr_gather_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin;
  logic [3:0] port_pins;
  logic [3:0] periph_evt;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, wmask;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       cpu_ack, cpu_reti;
  logic       irq_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  intr_gather uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
    .periph_evt(periph_evt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wmask(wmask), .rd_en(rd_en), .rd_data(rd_data), .cpu_ack(cpu_ack),
    .cpu_reti(cpu_reti), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m);
    wr_en = 1'b1; addr = a; wdata = d; wmask = m;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic snap_port();
    rd_en = 1'b1; addr = 2'd1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ext_pin = 1'b0; port_pins = '0; periph_evt = '0;
    wr_en = 1'b0; addr = '0; wdata = '0; wmask = '0; rd_en = 1'b0;
    cpu_ack = 1'b0; cpu_reti = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk($sformatf("R9 reg %0d after reset", a), v, 0);
    end
    chk("R9 irq after reset", irq_out, 0);

    // R6 masked write, R10 unused bits
    wr(2'd0, 8'hFF, 8'h05);
    rd(2'd0, v); chk("R6 masked write sets bits 0,2", v, 8'h05);
    wr(2'd0, 8'h00, 8'h04);
    rd(2'd0, v); chk("R6 masked write clears only bit 2", v, 8'h01);
    wr(2'd0, 8'hFF, 8'hFF);
    rd(2'd0, v); chk("R10 control bits 7:5 read 0", v, 8'h1F);
    wr(2'd1, 8'hFF, 8'h0F);
    rd(2'd1, v); chk("R10 flag bits 3:2 read 0, pins 0", v, 8'h03);
    wr(2'd2, 8'hFF, 8'hFF);
    rd(2'd2, v); chk("R10 peripheral flags above count read 0", v, 8'h0F);
    wr(2'd0, 8'h00, 8'hFF);
    wr(2'd1, 8'h00, 8'hFF);
    wr(2'd2, 8'h00, 8'hFF);

    // R5 / R6 exhaustive sweep of enables and forced flags
    for (int s = 0; s < 16384; s++) begin
      logic [3:0] ctl, pf, pe;
      logic [1:0] cf;
      logic exp;
      ctl = s[3:0]; cf = s[5:4]; pf = s[9:6]; pe = s[13:10];
      wr(2'd0, {4'b0, ctl}, 8'hFF);
      wr(2'd1, {6'b0, cf}, 8'hFF);
      wr(2'd2, {4'b0, pf}, 8'hFF);
      wr(2'd3, {4'b0, pe}, 8'hFF);
      exp = ctl[0] & ((cf[0] & ctl[2]) | (cf[1] & ctl[3]) | (ctl[1] & |(pf & pe)));
      chk($sformatf("R5 irq sweep %0d", s), irq_out, exp);
      if (s % 1024 == 0) begin
        rd(2'd2, v);
        chk($sformatf("R6 forced flags readback %0d", s), v, {4'b0, pf});
      end
    end
    wr(2'd0, 8'h00, 8'hFF);
    wr(2'd1, 8'h00, 8'hFF);
    wr(2'd2, 8'h00, 8'hFF);
    wr(2'd3, 8'h00, 8'hFF);

    // R1 / R2 external edge, enables all off
    wr(2'd0, 8'h10, 8'h10);   // rising
    ext_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R1 rising: flag clear at 2nd edge", v[0], 0);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R1 rising: flag set at 3rd edge", v[0], 1);
    chk("R1 masked flag gives no irq", irq_out, 0);
    wr(2'd1, 8'h00, 8'h01);
    ext_pin = 1'b0; idle(4);
    rd(2'd1, v); chk("R2 falling edge ignored in rising mode", v[0], 0);
    wr(2'd0, 8'h00, 8'h10);   // falling
    ext_pin = 1'b1; idle(4);
    rd(2'd1, v); chk("R2 rising edge ignored in falling mode", v[0], 0);
    ext_pin = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R1 falling: flag clear at 2nd edge", v[0], 0);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R1 falling: flag set at 3rd edge", v[0], 1);
    wr(2'd1, 8'h00, 8'h01);

    // R3 port change on every pin, both directions
    for (int p = 0; p < 4; p++) begin
      port_pins = 4'(1 << p); idle(4);
      rd(2'd1, v);
      chk($sformatf("R3 pin %0d rise sets flag", p), v[1], 1);
      chk($sformatf("R3 pin %0d readback", p), {28'b0, v[7:4]}, 32'(1 << p));
      wr(2'd1, 8'h00, 8'h02);
      rd(2'd1, v); chk($sformatf("R3 pin %0d clear fails on mismatch", p), v[1], 1);
      snap_port();
      wr(2'd1, 8'h00, 8'h02);
      rd(2'd1, v); chk($sformatf("R3 pin %0d clear after read", p), v[1], 0);
      port_pins = '0; idle(4);
      rd(2'd1, v); chk($sformatf("R3 pin %0d fall sets flag", p), v[1], 1);
      snap_port();
      wr(2'd1, 8'h00, 8'h02);
      rd(2'd1, v); chk($sformatf("R3 pin %0d cleared again", p), v[1], 0);
    end

    // R4 peripheral pulses with enables off but group and global on
    wr(2'd0, 8'h03, 8'hFF);
    for (int i = 0; i < 4; i++) begin
      periph_evt = 4'(1 << i);
      @(posedge clk); @(negedge clk);
      periph_evt = '0;
      rd(2'd2, v); chk($sformatf("R4 event %0d sets flag", i), v, 8'(1 << i));
      chk($sformatf("R4 masked event %0d gives no irq", i), irq_out, 0);
      wr(2'd2, 8'h00, 8'hFF);
    end

    // R7 event and clear in one cycle
    wr(2'd2, 8'h0F, 8'hFF);
    periph_evt = 4'b0100;
    wr(2'd2, 8'h00, 8'hFF);
    periph_evt = '0;
    rd(2'd2, v); chk("R7 set wins over clear", v, 8'h04);
    wr(2'd2, 8'h00, 8'hFF);

    // R8 acknowledge and return
    wr(2'd0, 8'h05, 8'hFF);
    wr(2'd1, 8'h01, 8'h01);
    chk("R8 forced flag raises irq", irq_out, 1);
    cpu_ack = 1'b1; @(posedge clk); @(negedge clk); cpu_ack = 1'b0;
    chk("R8 ack drops irq", irq_out, 0);
    rd(2'd0, v); chk("R8 ack clears global enable", v[0], 0);
    cpu_reti = 1'b1; @(posedge clk); @(negedge clk); cpu_reti = 1'b0;
    chk("R8 return restores irq", irq_out, 1);
    cpu_ack = 1'b1; cpu_reti = 1'b1; @(posedge clk); @(negedge clk);
    cpu_ack = 1'b0; cpu_reti = 1'b0;
    rd(2'd0, v); chk("R8 ack beats return", v[0], 0);
    cpu_ack = 1'b1; wr(2'd0, 8'h01, 8'h01); cpu_ack = 1'b0;
    rd(2'd0, v); chk("R8 ack beats enabling write", v[0], 0);
    chk("R8 irq stays low", irq_out, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule